// File: doc/BRIEF.md
# I2C Bus Line Conditioner and Address Recognizer

This block sits on the receive side of a two-wire serial bus port. It takes the raw clock and data lines and brings both into the system clock domain. It then removes short spikes and reports bus START and STOP conditions as single-cycle pulses. After each START it collects the first byte on the bus. The upper seven bits are compared with a programmed node address. If general-call detection is enabled, the whole byte is also tested against zero.

When either comparison succeeds, a sticky status flag and an interrupt request are raised, and the received direction bit is latched. The block also asserts a pull-down enable that drives the data line low for the acknowledge clock. When neither comparison succeeds, the line stays released and the block ignores bus traffic until the next START. Data bytes after the address, master operation and 10-bit addressing are handled elsewhere.

No data stream crosses this block's boundary, so it has no valid/ready handshake. All pins are plain control and status signals. The owner of the interrupt acknowledges it with a one-cycle clear strobe.

Top module: `i2c_addr_front`

## Requirements
- R1: Each raw line passes through a two-flop synchronizer and then a stability filter. A level held on the raw pin for at least three clocks appears on the filtered output after the fourth rising edge that follows the first edge sampling it. A raw pulse of one or two clocks never reaches the filtered output.
- R2: `start_p` is high for one cycle when filtered SDA goes from 1 to 0 while filtered SCL was 1 before and after that change. `stop_p` is the same condition for filtered SDA going from 0 to 1.
- R3: After a START, address bits are taken MSB first on each rising edge of filtered SCL. The eighth bit is the direction bit, and on a match it is presented on `rw_bit` (1 = read).
- R4: When bits 7..1 of the first byte equal `own_addr`, `addr_hit` and `irq` are set.
- R5: When `gc_en` is 1 and the first byte is 0x00, `gc_hit` and `irq` are set. When `gc_en` is 0, `gc_hit` is never set.
- R6: On a match, `sda_pull` rises at the first filtered SCL falling edge after the eighth bit. It stays high through the ninth clock and drops at the filtered SCL falling edge that ends it.
- R7: Without a match, `sda_pull` stays 0. Further bits, including a byte equal to the own address, have no effect until the next START.
- R8: A repeated START in the middle of a byte discards the partial bits, and capture restarts from the first bit.
- R9: `addr_hit`, `gc_hit`, `rw_bit` and `irq` stay set across STOP and later traffic until `irq_clr` is pulsed, which clears all four.
- R10: A STOP returns the recognizer to idle with `sda_pull` low.
- R11: While and after reset, `scl_f` and `sda_f` are 1 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_raw | input | 1 | Raw bus clock line |
| sda_raw | input | 1 | Raw bus data line |
| own_addr | input | 7 | Programmed node address |
| gc_en | input | 1 | Enables general-call recognition |
| irq_clr | input | 1 | One-cycle strobe clearing flags and interrupt |
| scl_f | output | 1 | Filtered clock line |
| sda_f | output | 1 | Filtered data line |
| start_p | output | 1 | START condition pulse |
| stop_p | output | 1 | STOP condition pulse |
| addr_hit | output | 1 | Own address matched (sticky) |
| gc_hit | output | 1 | General call matched (sticky) |
| rw_bit | output | 1 | Direction bit of the matched byte |
| sda_pull | output | 1 | Drive data line low (acknowledge) |
| irq | output | 1 | Interrupt request (sticky) |

## Verification
The properties assume that `irq_clr` is not pulsed between a match and the end of its acknowledge clock. They also assume that `gc_en` and `own_addr` are held steady while an address byte is on the bus. The stimulus changes these inputs only while the bus is idle or a transfer is finished. It also keeps every intended bus phase at eight clocks, well above the spike limit. Spikes are injected only as deliberate one-, two- and three-clock pulses on an idle bus.

// File: rtl/i2c_af_pkg.sv
package i2c_af_pkg;
  localparam int ADDR_W    = 7;
  localparam int SYNC_LEN  = 2;
  localparam int STABLE_N  = 3;

  typedef enum logic [2:0] {
    CAP_IDLE,
    CAP_SHIFT,
    CAP_ACK_WAIT,
    CAP_ACK,
    CAP_DONE,
    CAP_IGNORE
  } cap_state_t;
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int SYNC_LEN = 2,
  parameter int STABLE_N = 3,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(STABLE_N + 1);

  logic [SYNC_LEN-1:0] sync_q;
  logic [CW-1:0]       run_q;
  logic                filt_q;
  logic                synced;

  assign synced = sync_q[SYNC_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= {SYNC_LEN{RST_VAL}};
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], din};
    end
  end

  // Level moves only after STABLE_N consecutive differing samples.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      filt_q <= RST_VAL;
    end else if (synced == filt_q) begin
      run_q <= '0;
    end else if (run_q == CW'(STABLE_N - 1)) begin
      run_q  <= '0;
      filt_q <= synced;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign dout = filt_q;
endmodule

// File: rtl/bus_events.sv
module bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign start_p  = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_p   = scl_f & scl_d & ~sda_d & sda_f;
endmodule

// File: rtl/addr_catcher.sv
module addr_catcher
  import i2c_af_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_f,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic [AW-1:0] own_addr,
  input  logic          gc_en,
  input  logic          irq_clr,
  output logic          addr_hit,
  output logic          gc_hit,
  output logic          rw_bit,
  output logic          sda_pull,
  output logic          irq
);
  localparam int BW = AW + 1;
  localparam int CW = $clog2(BW);

  cap_state_t     st;
  logic [BW-2:0]  shreg;
  logic [CW-1:0]  bitcnt;
  logic [BW-1:0]  rx_byte;
  logic           last_bit, own_eq, gc_eq, set_own, set_gc;

  assign rx_byte  = {shreg, sda_f};
  assign last_bit = (st == CAP_SHIFT) && scl_rise && (bitcnt == CW'(BW - 1));
  assign own_eq   = (rx_byte[BW-1:1] == own_addr);
  assign gc_eq    = gc_en && (rx_byte == '0);
  assign set_own  = last_bit && own_eq;
  assign set_gc   = last_bit && gc_eq;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= CAP_IDLE;
      shreg    <= '0;
      bitcnt   <= '0;
      sda_pull <= 1'b0;
    end else if (stop_p) begin
      st       <= CAP_IDLE;
      sda_pull <= 1'b0;
    end else if (start_p) begin
      st       <= CAP_SHIFT;
      bitcnt   <= '0;
      sda_pull <= 1'b0;
    end else begin
      unique case (st)
        CAP_SHIFT: if (scl_rise) begin
          shreg  <= rx_byte[BW-2:0];
          bitcnt <= bitcnt + 1'b1;
          if (last_bit) st <= (own_eq || gc_eq) ? CAP_ACK_WAIT : CAP_IGNORE;
        end
        CAP_ACK_WAIT: if (scl_fall) begin
          sda_pull <= 1'b1;
          st       <= CAP_ACK;
        end
        CAP_ACK: if (scl_fall) begin
          sda_pull <= 1'b0;
          st       <= CAP_DONE;
        end
        default: ;
      endcase
    end
  end

  // Sticky status: a new match overrides a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_hit <= 1'b0;
      gc_hit   <= 1'b0;
      rw_bit   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (irq_clr) begin
        addr_hit <= 1'b0;
        gc_hit   <= 1'b0;
        rw_bit   <= 1'b0;
        irq      <= 1'b0;
      end
      if (set_own) addr_hit <= 1'b1;
      if (set_gc)  gc_hit   <= 1'b1;
      if (set_own || set_gc) begin
        rw_bit <= rx_byte[0];
        irq    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_addr_front.sv
module i2c_addr_front
  import i2c_af_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_raw,
  input  logic              sda_raw,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              irq_clr,
  output logic              scl_f,
  output logic              sda_f,
  output logic              start_p,
  output logic              stop_p,
  output logic              addr_hit,
  output logic              gc_hit,
  output logic              rw_bit,
  output logic              sda_pull,
  output logic              irq
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, filt_lines;
  logic              scl_rise, scl_fall;

  assign raw_lines = {sda_raw, scl_raw};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    line_filter #(
      .SYNC_LEN(SYNC_LEN),
      .STABLE_N(STABLE_N),
      .RST_VAL (1'b1)
    ) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw_lines[g]),
      .dout(filt_lines[g])
    );
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  bus_events u_evt (
    .clk     (clk),
    .rst     (rst),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_p (start_p),
    .stop_p  (stop_p)
  );

  addr_catcher #(.AW(ADDR_W)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .sda_f   (sda_f),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_p (start_p),
    .stop_p  (stop_p),
    .own_addr(own_addr),
    .gc_en   (gc_en),
    .irq_clr (irq_clr),
    .addr_hit(addr_hit),
    .gc_hit  (gc_hit),
    .rw_bit  (rw_bit),
    .sda_pull(sda_pull),
    .irq     (irq)
  );
endmodule

// File: rtl/i2c_addr_front_chk.sv
module i2c_addr_front_chk (
  input logic clk,
  input logic rst,
  input logic gc_en,
  input logic start_p,
  input logic stop_p,
  input logic addr_hit,
  input logic gc_hit,
  input logic sda_pull,
  input logic irq
);
  assert_irq_has_cause_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> (addr_hit || gc_hit));

  assert_gc_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(gc_hit) |-> $past(gc_en));

  assert_ack_only_on_match_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> (addr_hit || gc_hit));

  assert_start_releases_R8: assert property (@(posedge clk) disable iff (rst)
    start_p |=> !sda_pull);

  assert_stop_releases_R10: assert property (@(posedge clk) disable iff (rst)
    stop_p |=> !sda_pull);

  assert_no_start_and_stop_R2: assert property (@(posedge clk) disable iff (rst)
    start_p |=> !stop_p);
endmodule

bind i2c_addr_front i2c_addr_front_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .gc_en   (gc_en),
  .start_p (start_p),
  .stop_p  (stop_p),
  .addr_hit(addr_hit),
  .gc_hit  (gc_hit),
  .sda_pull(sda_pull),
  .irq     (irq)
);

// File: tb/sim_i2c_addr_front.sv
`timescale 1ns/1ps
module sim_i2c_addr_front;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_raw = 1'b1, sda_raw = 1'b1;
  logic [6:0] own_addr = 7'h52;
  logic       gc_en = 1'b1, irq_clr = 1'b0;
  logic       scl_f, sda_f, start_p, stop_p, addr_hit, gc_hit, rw_bit, sda_pull, irq;

  int total = 0, bad = 0;
  int n_start = 0, n_stop = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  i2c_addr_front u0 (
    .clk(clk), .rst(rst), .scl_raw(scl_raw), .sda_raw(sda_raw),
    .own_addr(own_addr), .gc_en(gc_en), .irq_clr(irq_clr),
    .scl_f(scl_f), .sda_f(sda_f), .start_p(start_p), .stop_p(stop_p),
    .addr_hit(addr_hit), .gc_hit(gc_hit), .rw_bit(rw_bit),
    .sda_pull(sda_pull), .irq(irq)
  );

  // Behavioural line model: two-sample delay, then a run-length rule.
  bit m_r1s = 1, m_r2s = 1, m_r1d = 1, m_r2d = 1;
  bit m_scl = 1, m_sda = 1, m_pscl = 1, m_psda = 1;
  int m_runs = 0, m_rund = 0;
  bit m_start = 0, m_stop = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_r1s = 1; m_r2s = 1; m_r1d = 1; m_r2d = 1;
      m_scl = 1; m_sda = 1; m_pscl = 1; m_psda = 1;
      m_runs = 0; m_rund = 0;
    end else begin
      m_pscl = m_scl; m_psda = m_sda;
      if (m_r2s != m_scl) m_runs++; else m_runs = 0;
      if (m_runs == 3) begin m_scl = m_r2s; m_runs = 0; end
      if (m_r2d != m_sda) m_rund++; else m_rund = 0;
      if (m_rund == 3) begin m_sda = m_r2d; m_rund = 0; end
      m_r2s = m_r1s; m_r1s = scl_raw;
      m_r2d = m_r1d; m_r1d = sda_raw;
    end
    m_start = m_scl && m_pscl && m_psda && !m_sda;
    m_stop  = m_scl && m_pscl && !m_psda && m_sda;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R1", "scl_f", scl_f, m_scl);
      chk("R1", "sda_f", sda_f, m_sda);
      chk("R2", "start_p", start_p, m_start);
      chk("R2", "stop_p", stop_p, m_stop);
      if (start_p) n_start++;
      if (stop_p) n_stop++;
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_raw = 1; wclk(Q);
    scl_raw = 1; wclk(Q);
    sda_raw = 0; wclk(Q);
    scl_raw = 0; wclk(Q);
  endtask

  task automatic bus_stop();
    scl_raw = 0; sda_raw = 0; wclk(Q);
    scl_raw = 1; wclk(Q);
    sda_raw = 1; wclk(Q);
  endtask

  task automatic send_bit(input bit b);
    sda_raw = b; wclk(Q);
    scl_raw = 1; wclk(2 * Q);
    scl_raw = 0; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  // Ninth clock: check pull before, during and after it.
  task automatic ack_clock(input string req, input bit exp_pull);
    chk(req, "sda_pull before ack clock", sda_pull, exp_pull);
    sda_raw = 1; wclk(Q);
    scl_raw = 1; wclk(Q);
    chk(req, "sda_pull mid ack clock", sda_pull, exp_pull);
    wclk(Q);
    scl_raw = 0; wclk(Q);
    chk("R6", "sda_pull after ack clock", sda_pull, 0);
  endtask

  task automatic pulse_clr();
    irq_clr = 1; wclk(1); irq_clr = 0; wclk(1);
  endtask

  task automatic chk_flags(input string req, input bit a, input bit g, input bit r, input bit i);
    chk(req, "addr_hit", addr_hit, a);
    chk(req, "gc_hit", gc_hit, g);
    chk(req, "rw_bit", rw_bit, r);
    chk(req, "irq", irq, i);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wclk(5);
    // R11 reset values
    chk("R11", "scl_f", scl_f, 1); chk("R11", "sda_f", sda_f, 1);
    chk("R11", "sda_pull", sda_pull, 0);
    chk_flags("R11", 0, 0, 0, 0);
    rst = 0; wclk(10);
    chk_flags("R11", 0, 0, 0, 0);

    // R4/R3: own address, read
    bus_start(); send_byte(8'hA5); ack_clock("R6", 1);
    chk_flags("R4", 1, 0, 1, 1);
    bus_stop(); wclk(4);
    chk("R10", "sda_pull after stop", sda_pull, 0);
    chk_flags("R9", 1, 0, 1, 1);
    pulse_clr();
    chk_flags("R9", 0, 0, 0, 0);

    // R3: own address, write, then a data byte; no second ack
    bus_start(); send_byte(8'hA4); ack_clock("R6", 1);
    chk_flags("R3", 1, 0, 0, 1);
    send_byte(8'hFF); ack_clock("R10", 0);
    bus_stop(); pulse_clr();

    // R5: general call enabled
    bus_start(); send_byte(8'h00); ack_clock("R5", 1);
    chk_flags("R5", 0, 1, 0, 1);
    bus_stop(); pulse_clr();

    // R5/R7: general call disabled, then own address without START
    gc_en = 0; wclk(2);
    bus_start(); send_byte(8'h00); ack_clock("R7", 0);
    chk_flags("R5", 0, 0, 0, 0);
    send_byte(8'hA4); ack_clock("R7", 0);
    chk_flags("R7", 0, 0, 0, 0);
    bus_stop(); gc_en = 1; wclk(2);

    // R7: foreign address
    bus_start(); send_byte(8'h30); ack_clock("R7", 0);
    chk_flags("R7", 0, 0, 0, 0);
    bus_stop();

    // R8: repeated START after three bits
    bus_start(); send_bit(1); send_bit(0); send_bit(0);
    bus_start(); send_byte(8'hA5); ack_clock("R8", 1);
    chk_flags("R8", 1, 0, 1, 1);
    bus_stop(); pulse_clr();

    // R1: spikes on an idle bus
    wclk(10);
    n_start = 0; n_stop = 0;
    sda_raw = 0; wclk(1); sda_raw = 1; wclk(10);
    sda_raw = 0; wclk(2); sda_raw = 1; wclk(10);
    scl_raw = 0; wclk(2); scl_raw = 1; wclk(10);
    chk("R1", "starts from short spikes", n_start, 0);
    chk("R1", "scl_f after spike", scl_f, 1);
    sda_raw = 0; wclk(3); sda_raw = 1; wclk(12);
    chk("R1", "starts from 3-clock pulse", n_start, 1);
    chk("R2", "stops from 3-clock pulse", n_stop, 1);
    chk_flags("R1", 0, 0, 0, 0);

    wclk(5);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule